// File: doc/BRIEF.md
# Locked Register Window for a Performance Counter Core

This block is the memory-mapped front of a performance counter core. It decodes a 4 KB window of 32-bit words on a simple internal register bus. Reads and writes that fall on the counter core's registers pass straight through to the core: event counters, event-type selectors, the cycle counter, the count-enable set register, the software increment register and the control register. The window also answers on its own for a set of read-only identification words. These are a 64-bit peripheral ID spread one byte per word, and mirrors of processor identification values that arrive on input ports.

A software lock is engaged out of reset. While it is engaged, no write reaches the core, although reads are always served. Software releases the lock by writing a fixed 32-bit key to the lock-access word. Any other value written there engages the lock again. The lock state is visible on an output pin and in a read-only status word.

A request is accepted in one cycle. A forwarded access shows on the core side in the same cycle, and read data comes back one cycle later with a valid strobe.

Top module: `pmu_mmio_window`

## Requirements
- R1: A read request (`req_valid`=1, `req_write`=0) raises `rsp_valid` exactly one cycle later, with the read data on `rsp_rdata`. A write request raises no response.
- R2: After reset the lock is engaged (`lock_engaged`=1). While it is engaged, a write to any core register leaves `core_wr` low.
- R3: Writing 0xC5ACCE55 to offset 0xFB0 clears `lock_engaged` from the next cycle on. Writing any other value to 0xFB0 sets it, whether or not it was clear. This write is accepted even while locked.
- R4: The core registers sit at these byte offsets: event counter n at 0x000+4n, event type n at 0x400+4n (n below NUM_EVT=31), cycle counter at 0x07C, count-enable set at 0xC00, software increment at 0xCA0, and control at 0xE04. A read of one of them pulses `core_rd` in the request cycle with `core_addr` = offset[11:2], and returns `core_rdata` as sampled in that cycle.
- R5: An unlocked write to a core register pulses `core_wr` in the request cycle, with `core_addr` = offset[11:2] and `core_wdata` = `req_wdata`.
- R6: Offset 0xFB4 reads back the lock state in bit 0 (1 = engaged), with all other bits zero. Offset 0xFB0 reads as zero.
- R7: Peripheral ID byte k reads zero-extended in bits 7:0: bytes 0 to 3 at 0xFE0+4k, and bytes 4 to 7 at 0xFD0+4(k-4).
- R8: The peripheral ID returned is the PERIPH_ID parameter with bits 23:20 replaced by `main_id[23:20]`.
- R9: Offset 0xD00 returns `main_id`, 0xD0C returns `tlb_type` and 0xD24 returns `feat1_id`. With HAS_MPU=0, offset 0xD10 also returns `main_id`.
- R10: Unmapped offsets read as zero. Writes to unmapped or identification offsets never pulse `core_wr`, and they leave the value read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window (bits 1:0 ignored) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| core_rd | output | 1 | Read strobe toward the counter core |
| core_wr | output | 1 | Write strobe toward the counter core |
| core_addr | output | 10 | Word index of the core register |
| core_wdata | output | 32 | Write data toward the core |
| core_rdata | input | 32 | Core read data, valid in the cycle of `core_rd` |
| main_id | input | 32 | Processor main identification value |
| tlb_type | input | 32 | Processor TLB type value |
| feat1_id | input | 32 | Processor feature 1 value |
| mpu_type | input | 32 | Memory protection unit type, used when HAS_MPU=1 |
| lock_engaged | output | 1 | 1 while the software lock is engaged |

## Verification
The core-side strobes, address and write data are combinational, so the bench drives each request on a falling edge and samples them shortly after, before the next rising edge. The read response and the lock state update on the following rising edge, so the bench samples `rsp_valid`, `rsp_rdata` and `lock_engaged` at the next falling edge, before it drives the next request. Expected read data comes from a bench model that tracks the lock from the writes it issued. The core read data is a pure function of `core_addr` that the bench supplies itself, so every forwarded read has a known value.

// File: rtl/pmu_mmio_window.sv
module pmu_mmio_window #(
  parameter int          NUM_EVT   = 31,
  parameter logic [63:0] PERIPH_ID = 64'h0000_0014_008A_E5D7,
  parameter logic [31:0] LOCK_KEY  = 32'hC5AC_CE55,
  parameter bit          HAS_MPU   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        core_rd,
  output logic        core_wr,
  output logic [9:0]  core_addr,
  output logic [31:0] core_wdata,
  input  logic [31:0] core_rdata,
  input  logic [31:0] main_id,
  input  logic [31:0] tlb_type,
  input  logic [31:0] feat1_id,
  input  logic [31:0] mpu_type,
  output logic        lock_engaged
);

  localparam logic [9:0] W_CYC    = 10'h01F;
  localparam logic [9:0] W_TYPE0  = 10'h100;
  localparam logic [9:0] W_CNTEN  = 10'h300;
  localparam logic [9:0] W_SWINC  = 10'h328;
  localparam logic [9:0] W_CTRL   = 10'h381;
  localparam logic [9:0] W_MAIN   = 10'h340;
  localparam logic [9:0] W_TLB    = 10'h343;
  localparam logic [9:0] W_MPU    = 10'h344;
  localparam logic [9:0] W_FEAT1  = 10'h349;
  localparam logic [9:0] W_KEY    = 10'h3EC;
  localparam logic [9:0] W_STAT   = 10'h3ED;
  localparam logic [9:0] W_PIDHI  = 10'h3F4;
  localparam logic [9:0] W_PIDEND = 10'h3FB;
  localparam logic [9:0] N_EVT    = 10'(NUM_EVT);

  logic [9:0]  w;
  logic        rd_req, wr_req;
  logic        hit_core, hit_pid;
  logic        lock_q;
  logic [63:0] pid_eff;
  logic [7:0]  pid_byte;
  logic [31:0] mpu_val;
  logic [31:0] rd_mux;

  assign w      = req_addr[11:2];
  assign rd_req = req_valid & ~req_write;
  assign wr_req = req_valid &  req_write;

  assign hit_core = (w < N_EVT) || (w == W_CYC) ||
                    (w >= W_TYPE0 && w < W_TYPE0 + N_EVT) ||
                    (w == W_CNTEN) || (w == W_SWINC) || (w == W_CTRL);
  assign hit_pid  = (w >= W_PIDHI) && (w <= W_PIDEND);

  assign core_rd    = rd_req & hit_core;
  assign core_wr    = wr_req & hit_core & ~lock_q;
  assign core_addr  = w;
  assign core_wdata = req_wdata;

  assign pid_eff  = {PERIPH_ID[63:24], main_id[23:20], PERIPH_ID[19:0]};
  assign pid_byte = pid_eff[{w[2], w[1:0], 3'b000} +: 8];

  generate
    if (HAS_MPU) begin : g_mpu
      assign mpu_val = mpu_type;
    end else begin : g_nompu
      assign mpu_val = main_id;
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (hit_core)          rd_mux = core_rdata;
    else if (hit_pid)      rd_mux = {24'h0, pid_byte};
    else if (w == W_STAT)  rd_mux = {31'h0, lock_q};
    else if (w == W_MAIN)  rd_mux = main_id;
    else if (w == W_TLB)   rd_mux = tlb_type;
    else if (w == W_MPU)   rd_mux = mpu_val;
    else if (w == W_FEAT1) rd_mux = feat1_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_mux : '0;
      if (wr_req && w == W_KEY)
        lock_q <= (req_wdata != LOCK_KEY);
    end
  end

  assign lock_engaged = lock_q;

  a_r1_read_response: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  a_r1_no_write_response: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);
  a_r2_locked_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> lock_engaged);
  a_r3_unlock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_engaged) |-> $past(wr_req && req_addr[11:2] == W_KEY && req_wdata == LOCK_KEY));
  a_r7_pid_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_req && hit_pid) |-> rsp_rdata[31:8] == 24'h0);
  a_r5_write_only_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |-> !lock_engaged && req_write);

endmodule

// File: tb/pmu_mmio_window_test.sv
module pmu_mmio_window_test;
  localparam logic [63:0] PID = 64'h0000_0014_008A_E5D7;
  localparam logic [31:0] KEY = 32'hC5AC_CE55;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, core_rd, core_wr, lock_engaged;
  logic [31:0] rsp_rdata, core_wdata, core_rdata;
  logic [9:0]  core_addr;
  logic [31:0] main_id = 32'h413F_C092, tlb_type = 32'h0000_0C01;
  logic [31:0] feat1_id = 32'h0000_1131, mpu_type = 32'hDEAD_0800;

  int checks = 0, errors = 0;
  bit lock_m = 1, done = 0;

  always #10 clk = ~clk;
  assign core_rdata = {22'h2C9A5, core_addr};

  pmu_mmio_window uut (.*);

  function automatic bit is_core(logic [11:0] a);
    int w = int'(a[11:2]);
    return (w < 31) || (w == 31) || (w >= 256 && w < 287) ||
           (a[11:2] == 10'h300) || (a[11:2] == 10'h328) || (a[11:2] == 10'h381);
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a, bit lk);
    logic [63:0] p;
    logic [11:0] o;
    p = PID;
    p[23:20] = main_id[23:20];
    o = {a[11:2], 2'b00};
    if (is_core(a)) return {22'h2C9A5, a[11:2]};
    if (o >= 12'hFE0 && o <= 12'hFEC) return {24'h0, p[8*((o-12'hFE0)/4) +: 8]};
    if (o >= 12'hFD0 && o <= 12'hFDC) return {24'h0, p[8*(4+(o-12'hFD0)/4) +: 8]};
    case (o)
      12'hFB4: return {31'h0, lk};
      12'hD00, 12'hD10: return main_id;
      12'hD0C: return tlb_type;
      12'hD24: return feat1_id;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(bit wr, logic [11:0] a, logic [31:0] d, string tag);
    logic [31:0] er;
    bit ec;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    ec = is_core(a);
    er = exp_read(a, lock_m);
    #2;
    chk(core_rd == (!wr && ec), {tag, " R4 core_rd"}, 32'(core_rd), 32'(!wr && ec));
    chk(core_wr == (wr && ec && !lock_m), {tag, " R2/R5/R10 core_wr"}, 32'(core_wr), 32'(wr && ec && !lock_m));
    if (wr && ec && !lock_m)
      chk(core_wdata == d && core_addr == a[11:2], {tag, " R5 fwd"}, core_wdata, d);
    if (wr && a[11:2] == 10'h3EC) lock_m = (d != KEY);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == !wr, {tag, " R1 rsp_valid"}, 32'(rsp_valid), 32'(!wr));
    if (!wr) chk(rsp_rdata == er, {tag, " R4/R6/R7/R8/R9/R10 rdata"}, rsp_rdata, er);
    chk(lock_engaged == lock_m, {tag, " R3 lock"}, 32'(lock_engaged), 32'(lock_m));
  endtask

  function automatic logic [11:0] pick(int i);
    case (i)
      0: return 12'h000; 1: return 12'h078; 2: return 12'h07C; 3: return 12'h400;
      4: return 12'h478; 5: return 12'h47C; 6: return 12'hC00; 7: return 12'hCA0;
      8: return 12'hE04; 9: return 12'hFB0; 10: return 12'hFB4; 11: return 12'hFD0;
      12: return 12'hFDC; 13: return 12'hFE8; 14: return 12'hD00; 15: return 12'hD10;
      16: return 12'hD0C; 17: return 12'hD24; 18: return 12'h080;
      default: return 12'($urandom) & 12'hFFC;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(lock_engaged == 1, "R2 reset lock", 32'(lock_engaged), 1);
    chk(rsp_valid == 0, "R1 reset rsp", 32'(rsp_valid), 0);
    rst_n = 1;
    op(1, 12'h004, 32'h1111_2222, "R2 locked write");
    op(0, 12'hFB4, 0, "R6 status locked");
    op(0, 12'hFB0, 0, "R6 key reads zero");
    op(1, 12'hFB0, 32'h0000_ABCD, "R3 wrong key");
    op(1, 12'hFB0, KEY, "R3 key");
    op(0, 12'hFB4, 0, "R6 status unlocked");
    op(1, 12'hCA0, 32'h4000_0001, "R5 swinc write");
    op(1, 12'h47C, 32'h5, "R10 unmapped write");
    op(1, 12'hD00, 32'h5, "R10 id write");
    op(0, 12'hD00, 0, "R9 id after write");
    for (int k = 0; k < 4; k++) op(0, 12'hFE0 + 12'(4*k), 0, "R7 pid lo");
    for (int k = 0; k < 4; k++) op(0, 12'hFD0 + 12'(4*k), 0, "R7 pid hi");
    op(0, 12'hFE8, 0, "R8 variant");
    op(0, 12'hD10, 0, "R9 mpu mirror");
    op(0, 12'h07C, 0, "R4 cycle counter");
    op(0, 12'h080, 0, "R10 unmapped read");
    op(1, 12'hFB0, 32'h1, "R3 relock");
    op(1, 12'hE04, 32'h1, "R2 relocked write");
    for (int i = 0; i < 400; i++) begin
      int s = int'($urandom_range(0, 24));
      bit wr = 1'($urandom);
      logic [31:0] d = ($urandom_range(0, 3) == 0) ? KEY : $urandom;
      op(wr, pick(s) | 12'($urandom_range(0, 3)), d, "random");
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule